// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block runs a bank of general-purpose pins from two registers on a small register bus. A 32-bit configuration register holds a pair of bits for every pin: one makes the pin drive, the other turns on its pull-up. A 16-bit data register holds the value that each driving pin puts out. A read of the data register returns, bit by bit, the stored value for a driving pin and the synchronized pad level for a receiving pin.

There are three separate conditions that stop the block, and each treats the state differently. Power-on reset clears the configuration, so every pin starts as a receiver. Manual reset and standby keep the configuration. No condition ever touches the data latch. Its contents are undefined after power-up, so software loads it before it makes a pin drive. Manual reset clears the input synchronizer. Standby freezes it. While any of the three is active, or while a reset release is still passing through its synchronizer, the block ignores bus writes.

Top module: `gpio_bank`

## Requirements
- R1: While `por_n` is low, the configuration register is all zeros, with `pin_oe` = 0 and `pin_pu` = 0. A pulse on `por_n` in mid-run also clears it.
- R2: Configuration bit 2n is the drive enable of pin n (1 = output) and appears on `pin_oe[n]`. Bit 2n+1 is the pull-up enable of pin n (1 = on) and appears on `pin_pu[n]`. With `sel` = 0, a read returns all 32 bits as written, and a write takes effect at the next rising clock edge.
- R3: `pin_out[n]` equals data latch bit n when pin n drives, and it is 0 when pin n receives.
- R4: With `sel` = 1, `rdata[n]` is data latch bit n for a driving pin and the synchronized `pin_in[n]` for a receiving pin, and `rdata[31:16]` reads 0.
- R5: A change on `pin_in` shows up in a data-register read after exactly two rising clock edges, and not after one.
- R6: The data latch keeps its value through power-on reset, manual reset and standby.
- R7: Manual reset and standby leave the configuration register unchanged.
- R8: Bus writes to either register have no effect while `standby` is high, while `mrst_n` or `por_n` is low, or on the first clock edge after `por_n` rises.
- R9: While `mrst_n` is low, the input synchronizer is cleared, so receiving pins read 0.
- R10: While `standby` is high, input sampling stops and receiving pins keep reading the level they were sampled at before standby. Sampling resumes when standby ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| mrst_n | input | 1 | Manual reset, active low, asynchronous assert |
| standby | input | 1 | Standby request, active high |
| sel | input | 1 | Register select: 0 configuration, 1 data |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| pin_in | input | 16 | Pad input levels |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output value |
| pin_pu | output | 16 | Per-pin pull-up enable |

## Verification
The bench walks every mode of both control bits of every pin. A design that swapped the bit pairs or shifted the interleave would light up the wrong `pin_oe` or `pin_pu` line. It then mixes driving and receiving pins under several data and pad patterns. A read multiplexer selected by the wrong bit would return pad levels where stored values belong, or the reverse. The reset checks store a value, pulse each reset and standby in turn, and read it back. A latch or configuration register wired to the wrong reset would lose its contents. The bench also times the synchronizer edge by edge, which exposes a missing or extra stage. Finally, it writes during standby, during manual reset and in the cycle right after power-on release, where a leaky write gate would corrupt the stored state.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register select encoding on the bus
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;

  // Two configuration bits per pin: drive at the even position, pull-up above it
  typedef struct packed {
    logic pull_up;
    logic drive;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stage_q <= '0;
    else if (en) stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ctrl,
  input  logic                       wr_data,
  input  logic [2*NUM_PINS-1:0]      ctrl_wdata,
  input  logic [NUM_PINS-1:0]        data_wdata,
  output pin_cfg_t [NUM_PINS-1:0]    cfg_q,
  output logic [NUM_PINS-1:0]        dat_q
);

  pin_cfg_t [NUM_PINS-1:0] cfg_d;
  logic [NUM_PINS-1:0]     dat_d;

  // Next-state logic
  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctrl) cfg_d = ctrl_wdata;
  end

  always_comb begin
    dat_d = dat_q;
    if (wr_data) dat_d = data_wdata;
  end

  // Configuration: cleared only by power-on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // Data latch: no reset of any kind, holds until written
  always_ff @(posedge clk) begin
    if (wr_data) dat_q <= dat_d;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                mrst_n,
  input  logic                standby,
  input  logic                sel,
  input  logic                wr_en,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_pu
);

  localparam int CTRL_W = 2 * NUM_PINS;

  logic                    por_ok;
  logic                    mrst_ok;
  logic                    mrst_arst_n;
  logic                    wr_allow;
  logic                    wr_ctrl;
  logic                    wr_data;
  logic                    sync_en;
  reg_sel_e                sel_e;
  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic [CTRL_W-1:0]       cfg_bits;
  logic [NUM_PINS-1:0]     dat_q;
  logic [NUM_PINS-1:0]     pin_sync;
  logic [NUM_PINS-1:0]     rd_view;

  // Reset domains: power-on alone, and manual reset (which power-on also covers)
  assign mrst_arst_n = por_n & mrst_n;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_por_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (por_ok)
  );

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_mrst_sync (
    .clk     (clk),
    .arst_n  (mrst_arst_n),
    .rst_n_o (mrst_ok)
  );

  // Write gating
  assign sel_e    = reg_sel_e'(sel);
  assign wr_allow = wr_en & ~standby & por_ok & mrst_ok;
  assign wr_ctrl  = wr_allow & (sel_e == SEL_CTRL);
  assign wr_data  = wr_allow & (sel_e == SEL_DATA);

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk        (clk),
    .rst_n      (por_ok),
    .wr_ctrl    (wr_ctrl),
    .wr_data    (wr_data),
    .ctrl_wdata (wdata[CTRL_W-1:0]),
    .data_wdata (wdata[NUM_PINS-1:0]),
    .cfg_q      (cfg_q),
    .dat_q      (dat_q)
  );

  // Pad input sampling, frozen in standby
  assign sync_en = ~standby;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (mrst_ok),
    .en    (sync_en),
    .d     (pin_in),
    .q     (pin_sync)
  );

  // Per-pin fan-out and read view
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign pin_oe[n]  = cfg_q[n].drive;
    assign pin_pu[n]  = cfg_q[n].pull_up;
    assign pin_out[n] = cfg_q[n].drive & dat_q[n];
    assign rd_view[n] = cfg_q[n].drive ? dat_q[n] : pin_sync[n];
  end

  assign cfg_bits = cfg_q;

  always_comb begin
    rdata = '0;
    unique case (sel_e)
      SEL_CTRL: rdata = BUS_W'(cfg_bits);
      SEL_DATA: rdata = BUS_W'(rd_view);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 16,
  parameter int BUS_W    = 32
) (
  input logic                clk,
  input logic                por_n,
  input logic                mrst_n,
  input logic                standby,
  input logic                sel,
  input logic [BUS_W-1:0]    rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_pu
);

  localparam int CTRL_W = 2 * NUM_PINS;

  logic [CTRL_W-1:0] ctrl_view;

  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) begin
      ctrl_view[2*n]   = pin_oe[n];
      ctrl_view[2*n+1] = pin_pu[n];
    end
  end

  assert_por_clear_R1: assert property (@(posedge clk)
    !por_n |-> (pin_oe == '0 && pin_pu == '0));

  assert_ctrl_map_R2: assert property (@(posedge clk) disable iff (!por_n)
    !sel |-> (rdata[CTRL_W-1:0] == ctrl_view));

  assert_out_gate_R3: assert property (@(posedge clk) disable iff (!por_n)
    (pin_out & ~pin_oe) == '0);

  assert_rd_drive_R4: assert property (@(posedge clk) disable iff (!por_n)
    (sel && !$isunknown(pin_out)) |-> (((rdata[NUM_PINS-1:0] ^ pin_out) & pin_oe) == '0));

  assert_rd_upper_R4: assert property (@(posedge clk) disable iff (!por_n)
    sel |-> (rdata[BUS_W-1:NUM_PINS] == '0));

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    (standby || !mrst_n) |=> ($stable(pin_oe) && $stable(pin_pu)));

  assert_mrst_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && sel) |-> ((rdata[NUM_PINS-1:0] & ~pin_oe) == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W)) u_chk (
  .clk     (clk),
  .por_n   (por_n),
  .mrst_n  (mrst_n),
  .standby (standby),
  .sel     (sel),
  .rdata   (rdata),
  .pin_oe  (pin_oe),
  .pin_out (pin_out),
  .pin_pu  (pin_pu)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_n, mrst_n, standby, sel, wr_en;
  logic [31:0] wdata, rdata;
  logic [15:0] pin_in, pin_oe, pin_out, pin_pu;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby),
    .sel(sel), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  function automatic logic [31:0] spread(input logic [15:0] drv, input logic [15:0] pu);
    logic [31:0] v;
    for (int n = 0; n < 16; n++) begin
      v[2*n]   = drv[n];
      v[2*n+1] = pu[n];
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic s, input logic [31:0] d);
    sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic s, output logic [31:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] dv, dd, pv;
    por_n = 1'b0; mrst_n = 1'b1; standby = 1'b0;
    sel = 1'b0; wr_en = 1'b0; wdata = '0; pin_in = '0;
    wait_n(3);

    // R1: power-on state
    check("R1 oe", {16'h0, pin_oe}, 32'h0);
    check("R1 pu", {16'h0, pin_pu}, 32'h0);
    bus_rd(1'b0, r); check("R1 ctrl", r, 32'h0);

    // R8: write on first edge after power-on release is dropped
    por_n = 1'b1; sel = 1'b0; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    wait_n(3);
    bus_rd(1'b0, r); check("R8 por window", r, 32'h0);

    // R2: every mode of every pin
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] v;
        v = 32'(m) << (2*n);
        bus_wr(1'b0, v);
        check("R2 oe", {16'h0, pin_oe}, {16'h0, 16'(m & 1) << n});
        check("R2 pu", {16'h0, pin_pu}, {16'h0, 16'((m >> 1) & 1) << n});
        bus_rd(1'b0, r); check("R2 readback", r, v);
      end
    end

    // R3 / R4: mixed directions, data and pad patterns
    for (int i = 0; i < 24; i++) begin
      case (i % 6)
        0: dv = 16'h0000;
        1: dv = 16'hFFFF;
        2: dv = 16'h00FF;
        3: dv = 16'hAAAA;
        4: dv = 16'h5555;
        default: dv = 16'h1 << i[3:0];
      endcase
      dd = 16'(16'h1357 * (i + 3));
      pv = {dd[6:0], dd[15:7]} ^ 16'hC3A5;
      bus_wr(1'b1, {16'h0, dd});
      bus_wr(1'b0, spread(dv, ~dv));
      pin_in = pv;
      wait_n(3);
      check("R3 pin_out", {16'h0, pin_out}, {16'h0, dd & dv});
      check("R2 pin_pu mix", {16'h0, pin_pu}, {16'h0, ~dv});
      bus_rd(1'b1, r); check("R4 data read", r, {16'h0, (dd & dv) | (pv & ~dv)});
    end

    // R5: two-edge input latency
    bus_wr(1'b0, 32'h0);
    pin_in = 16'h0; wait_n(3);
    pin_in = 16'h3C3C;
    @(negedge clk); bus_rd(1'b1, r); check("R5 one edge", r, 32'h0);
    @(negedge clk); bus_rd(1'b1, r); check("R5 two edges", r, 32'h3C3C);

    // R6 / R7: retention through manual reset, standby, power-on reset
    bus_wr(1'b1, 32'h6E91);
    bus_wr(1'b0, 32'h5555_5555);
    mrst_n = 1'b0; wait_n(3);
    bus_rd(1'b0, r); check("R7 ctrl in mrst", r, 32'h5555_5555);
    mrst_n = 1'b1; wait_n(4);
    bus_rd(1'b0, r); check("R7 ctrl after mrst", r, 32'h5555_5555);
    bus_rd(1'b1, r); check("R6 data after mrst", r, 32'h6E91);
    standby = 1'b1; wait_n(3); standby = 1'b0; wait_n(1);
    bus_rd(1'b0, r); check("R7 ctrl after standby", r, 32'h5555_5555);
    bus_rd(1'b1, r); check("R6 data after standby", r, 32'h6E91);
    por_n = 1'b0; wait_n(2);
    bus_rd(1'b0, r); check("R1 mid-run por", r, 32'h0);
    por_n = 1'b1; wait_n(4);
    bus_wr(1'b0, 32'h5555_5555);
    bus_rd(1'b1, r); check("R6 data after por", r, 32'h6E91);

    // R8: writes ignored in standby and manual reset
    standby = 1'b1;
    bus_wr(1'b0, 32'hFFFF_FFFF);
    bus_wr(1'b1, 32'h0000);
    bus_rd(1'b0, r); check("R8 standby ctrl", r, 32'h5555_5555);
    bus_rd(1'b1, r); check("R8 standby data", r, 32'h6E91);
    standby = 1'b0;
    mrst_n = 1'b0; wait_n(1);
    bus_wr(1'b0, 32'hFFFF_FFFF);
    bus_wr(1'b1, 32'h0000);
    bus_rd(1'b0, r); check("R8 mrst ctrl", r, 32'h5555_5555);
    bus_rd(1'b1, r); check("R8 mrst data", r, 32'h6E91);
    mrst_n = 1'b1; wait_n(4);

    // R9: manual reset clears the input synchronizer
    bus_wr(1'b0, 32'h0);
    pin_in = 16'hFFFF; wait_n(3);
    bus_rd(1'b1, r); check("R9 before", r, 32'hFFFF);
    mrst_n = 1'b0;
    bus_rd(1'b1, r); check("R9 during mrst", r, 32'h0);
    wait_n(2);
    bus_rd(1'b1, r); check("R9 held low", r, 32'h0);
    mrst_n = 1'b1; wait_n(4);
    bus_rd(1'b1, r); check("R9 after", r, 32'hFFFF);

    // R10: standby freezes sampling
    pin_in = 16'h0F0F; wait_n(3);
    standby = 1'b1;
    pin_in = 16'hF0F0; wait_n(3);
    bus_rd(1'b1, r); check("R10 frozen", r, 32'h0F0F);
    standby = 1'b0; wait_n(3);
    bus_rd(1'b1, r); check("R10 resumed", r, 32'hF0F0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule